// File: doc/BRIEF.md
# Automatic performance report inserter

This block sits in the transmit data link path of a T1 framer. A one-second strobe makes it build a performance report. In the same second it counts four kinds of receive error events: CRC errors, framing-pattern errors, severely-errored-frame events and frame-error events. At each strobe it latches those counts and encodes them into a status window. It keeps the current window and the three older ones. A report is formed from a fixed three-octet header, the four windows and the fixed bits written by the processor. The report is sent as an HDLC frame with zero stuffing and a 16-bit FCS, and it needs no space in the general message FIFO.

Only one source drives the data link output in each FDL bit slot. The slot is marked by `bit_en`, and the source is the report path, the message FIFO or the bit-oriented priority code word source. A pending report waits until the FIFO is empty. It waits for a running code word stream to end, except when the priority mode gives the report path precedence. In that case it cuts into the code word stream. Between reports the report path sends continuous flags.

The frame engine has four states. IDLE sends idle flags. The transition OPEN leaves IDLE after a complete flag when a report may start, and takes a snapshot of the report contents. BODY sends the header and the window octets. The transition SEAL moves from BODY to FCS after the last body bit. FCS sends the 16 check bits. The transition TAIL moves from FCS to CLOSE, which sends the closing flag. The transition REST returns to IDLE after the last flag bit.

Top module: `prm_inserter`

## Requirements
- R1: A write to `cfg_wdata` with `cfg_wr` stores bits 7..2 and bit 0 in the control register, which is visible on `cfg_q`. Bit 1 always reads 0. Bit 7 is auto enable, bit 6 C/R, bit 5 R, bit 4 U1, bit 3 U2, bit 2 SL and bit 0 send request.
- R2: With bit 7 set, each `one_sec` strobe queues exactly one report. With bit 7 clear, a strobe queues none.
- R3: Setting bit 0 queues one report even with bit 7 clear. Bit 0 clears when that report begins transmission.
- R4: Each report is framed by 0x7E flags. Bits go out LSB first, and a 0 is inserted after five consecutive 1s between the flags. The frame is 11 data octets followed by an inverted CRC-16/CCITT (reflected, initial value 0xFFFF), sent LSB first. Running the CRC over the data and the FCS gives the residue 0xF0B8.
- R5: The header octets are {6'b001110, C/R, 0}, then 0x01, then 0x03.
- R6: Each window is two octets, high octet first. High octet bits 7..2 are the CRC-count bins G6..G1 (one-hot): G1 for exactly 1, G2 for 2 to 5, G3 for 6 to 10, G4 for 11 to 100, G5 for 101 to 319, G6 for 320 or more. All bins are 0 when the count is 0.
- R7: High octet bit 1 is set if any severely-errored-frame event was counted, and bit 0 if any framing-pattern error was counted. Low octet bit 7 is set if any frame-error event was counted.
- R8: There are four windows, newest first, and they shift by one at each strobe. Low octet bits 1..0 hold a modulo-4 sequence number that advances at each strobe.
- R9: Low octet bits 6..3 are SL, U1, U2 and R, taken from the control register. Bit 2 is 0.
- R10: A report starts only while `fifo_empty` is high. `dl_src` encodes the source: 0 is the report path or idle flags, 1 is the FIFO, 2 is code words. With `dl_src` at 1 or 2, `dl_bit` repeats `fifo_bit` or `bop_bit` respectively.
- R11: While `bop_active` is high, a pending report starts only if `prio_mode` is 2'b11. Otherwise the report waits.
- R12: A strobe while a report is pending replaces the window contents and does not queue a second report. A strobe during transmission changes neither the running frame nor the queue.
- R13: `dl_bit` and `dl_src` change only on `bit_en`. The report path idles with flags, and a started frame runs to its closing flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | FDL bit slot strobe |
| one_sec | input | 1 | One-second strobe |
| crc_evt | input | 1 | CRC error event pulse |
| fps_evt | input | 1 | Framing-pattern error event pulse |
| sef_evt | input | 1 | Severely-errored-frame event pulse |
| fred_evt | input | 1 | Frame-error event pulse |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_q | output | 8 | Control register contents |
| prio_mode | input | 2 | Output priority mode; 2'b11 lets reports cut into code words |
| fifo_empty | input | 1 | Message FIFO is empty |
| fifo_bit | input | 1 | Serial bit from the message FIFO path |
| bop_active | input | 1 | Code word stream is running |
| bop_bit | input | 1 | Serial bit from the code word source |
| dl_bit | output | 1 | Data link output bit |
| dl_src | output | 2 | Source of the current output bit |

## Verification
The report contents are tried with CRC counts drawn from both sides of every bin edge. These are mixed with random counts of the other three event kinds and random fixed bits, which separates the bin decode, the flag bits and the register merge. Count patterns change from second to second, so a wrong shift order or a stale window gives a different frame. Directed runs hold the FIFO busy, raise the code word source under both priority modes, and pulse the strobe while a report is pending and again mid-frame. These runs tell waiting apart from pre-emption, and replacement apart from double queuing. The decoder in the bench removes stuffing and checks the CRC residue, so a misplaced stuffed bit or a wrong FCS breaks a frame.

// File: rtl/prm_pkg.sv
package prm_pkg;

    localparam logic [7:0] FLAG_BYTE = 8'h7E;

    typedef enum logic [1:0] {
        SRC_RPT  = 2'd0,
        SRC_FIFO = 2'd1,
        SRC_BOP  = 2'd2
    } src_e;

    typedef enum logic [1:0] {
        SER_IDLE,
        SER_BODY,
        SER_FCS,
        SER_CLOSE
    } ser_st_e;

    // one latched second of status
    typedef struct packed {
        logic [5:0] g;     // CRC-count bins, g[0] = G1
        logic       se;
        logic       fe;
        logic       lv;
        logic [1:0] seq;
    } win_t;

    function automatic logic [15:0] crc16_lsb(input logic [15:0] c, input logic b);
        crc16_lsb = {1'b0, c[15:1]} ^ (((c[0] ^ b) == 1'b1) ? 16'h8408 : 16'h0000);
    endfunction

endpackage

// File: rtl/prm_evt_hist.sv
module prm_evt_hist
    import prm_pkg::*;
#(
    parameter int CNT_W = 9,
    parameter int NWIN  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       one_sec,
    input  logic [3:0] evt,          // [0] crc, [1] fps, [2] sef, [3] fred
    output win_t       win_o [NWIN]
);
    localparam int G2_MIN = 2;
    localparam int G3_MIN = 6;
    localparam int G4_MIN = 11;
    localparam int G5_MIN = 101;
    localparam int G6_MIN = 320;

    logic [CNT_W-1:0] cnt_q [4];
    logic [1:0]       seq_q;
    win_t             win_q [NWIN];
    win_t             fresh;

    always_comb begin
        int c;
        c = int'(cnt_q[0]);
        fresh.g = 6'b000000;
        if (c >= G6_MIN)      fresh.g = 6'b100000;
        else if (c >= G5_MIN) fresh.g = 6'b010000;
        else if (c >= G4_MIN) fresh.g = 6'b001000;
        else if (c >= G3_MIN) fresh.g = 6'b000100;
        else if (c >= G2_MIN) fresh.g = 6'b000010;
        else if (c == 1)      fresh.g = 6'b000001;
        fresh.fe  = |cnt_q[1];
        fresh.se  = |cnt_q[2];
        fresh.lv  = |cnt_q[3];
        fresh.seq = seq_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= 2'd0;
            for (int k = 0; k < 4; k++) cnt_q[k] <= '0;
            for (int i = 0; i < NWIN; i++) win_q[i] <= '0;
        end else if (one_sec) begin
            seq_q <= seq_q + 2'd1;
            for (int k = 0; k < 4; k++) cnt_q[k] <= '0;
            win_q[0] <= fresh;
            for (int i = 1; i < NWIN; i++) win_q[i] <= win_q[i-1];
        end else begin
            for (int k = 0; k < 4; k++)
                if (evt[k] && cnt_q[k] != '1) cnt_q[k] <= cnt_q[k] + 1'b1;
        end
    end

    assign win_o = win_q;

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        one_sec |=> (win_q[1] == $past(win_q[0]))); // R8
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        one_sec |=> (win_q[0].seq == $past(seq_q))); // R8

endmodule

// File: rtl/prm_hdlc_tx.sv
module prm_hdlc_tx
    import prm_pkg::*;
#(
    parameter int NBYTES = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                req,
    input  logic [NBYTES*8-1:0] body,
    output logic                nbit,
    output logic                busy,
    output logic                start
);
    localparam int BW = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    ser_st_e             st_q, st_d;
    logic [2:0]          fidx_q, fidx_d, bit_q, bit_d, ones_q, ones_d;
    logic [BW-1:0]       byte_q, byte_d;
    logic [15:0]         crc_q, crc_d, fcs_q, fcs_d;
    logic [3:0]          fcnt_q, fcnt_d;
    logic [NBYTES*8-1:0] snap_q, snap_d;
    logic                go;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SER_IDLE;
            fidx_q <= '0;
            bit_q  <= '0;
            ones_q <= '0;
            byte_q <= '0;
            crc_q  <= 16'hFFFF;
            fcs_q  <= '0;
            fcnt_q <= '0;
            snap_q <= '0;
        end else if (en) begin
            st_q   <= st_d;
            fidx_q <= fidx_d;
            bit_q  <= bit_d;
            ones_q <= ones_d;
            byte_q <= byte_d;
            crc_q  <= crc_d;
            fcs_q  <= fcs_d;
            fcnt_q <= fcnt_d;
            snap_q <= snap_d;
        end
    end

    always_comb begin
        logic db;
        st_d   = st_q;
        fidx_d = fidx_q;
        bit_d  = bit_q;
        ones_d = ones_q;
        byte_d = byte_q;
        crc_d  = crc_q;
        fcs_d  = fcs_q;
        fcnt_d = fcnt_q;
        snap_d = snap_q;
        nbit   = 1'b0;
        go     = 1'b0;
        db     = 1'b0;
        unique case (st_q)
            SER_IDLE: begin
                nbit   = FLAG_BYTE[fidx_q];
                fidx_d = fidx_q + 3'd1;
                if (fidx_q == 3'd7 && req) begin       // OPEN
                    go     = 1'b1;
                    st_d   = SER_BODY;
                    byte_d = '0;
                    bit_d  = '0;
                    ones_d = '0;
                    crc_d  = 16'hFFFF;
                    snap_d = body;
                end
            end
            SER_BODY: begin
                if (ones_q == 3'd5) begin
                    ones_d = '0;
                end else begin
                    db     = snap_q[int'(byte_q)*8 + int'(bit_q)];
                    nbit   = db;
                    ones_d = db ? ones_q + 3'd1 : 3'd0;
                    crc_d  = crc16_lsb(crc_q, db);
                    bit_d  = bit_q + 3'd1;
                    if (bit_q == 3'd7) begin
                        if (int'(byte_q) == NBYTES-1) begin  // SEAL
                            st_d   = SER_FCS;
                            fcs_d  = ~crc16_lsb(crc_q, db);
                            fcnt_d = '0;
                        end else begin
                            byte_d = byte_q + 1'b1;
                        end
                    end
                end
            end
            SER_FCS: begin
                if (ones_q == 3'd5) begin
                    ones_d = '0;
                end else begin
                    db     = fcs_q[0];
                    nbit   = db;
                    ones_d = db ? ones_q + 3'd1 : 3'd0;
                    fcs_d  = {1'b0, fcs_q[15:1]};
                    fcnt_d = fcnt_q + 4'd1;
                    if (fcnt_q == 4'd15) begin         // TAIL
                        st_d   = SER_CLOSE;
                        fidx_d = '0;
                    end
                end
            end
            SER_CLOSE: begin
                if (ones_q == 3'd5) begin
                    ones_d = '0;
                end else begin
                    nbit   = FLAG_BYTE[fidx_q];
                    ones_d = '0;
                    fidx_d = fidx_q + 3'd1;
                    if (fidx_q == 3'd7) st_d = SER_IDLE; // REST
                end
            end
        endcase
    end

    assign start = en & go;
    assign busy  = (st_q != SER_IDLE);

endmodule

// File: rtl/prm_inserter.sv
module prm_inserter
    import prm_pkg::*;
#(
    parameter int CNT_W = 9,
    parameter int NWIN  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       one_sec,
    input  logic       crc_evt,
    input  logic       fps_evt,
    input  logic       sef_evt,
    input  logic       fred_evt,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_q,
    input  logic [1:0] prio_mode,
    input  logic       fifo_empty,
    input  logic       fifo_bit,
    input  logic       bop_active,
    input  logic       bop_bit,
    output logic       dl_bit,
    output logic [1:0] dl_src
);
    localparam int         HDR    = 3;
    localparam int         NBYTES = HDR + 2*NWIN;
    localparam logic [7:0] WMASK  = 8'hFD;

    win_t                win [NWIN];
    logic [NBYTES*8-1:0] body;
    logic                pend_q, want, may_go, ser_en, ser_bit, ser_busy, ser_start;
    src_e                src;

    prm_evt_hist #(.CNT_W(CNT_W), .NWIN(NWIN)) hist_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .one_sec (one_sec),
        .evt     ({fred_evt, sef_evt, fps_evt, crc_evt}),
        .win_o   (win)
    );

    assign body[7:0]   = {6'b001110, cfg_q[6], 1'b0};
    assign body[15:8]  = 8'h01;
    assign body[23:16] = 8'h03;
    for (genvar i = 0; i < NWIN; i++) begin : g_win
        assign body[(HDR+2*i)*8 +: 8]   = {win[i].g, win[i].se, win[i].fe};
        assign body[(HDR+2*i+1)*8 +: 8] = {win[i].lv, cfg_q[2], cfg_q[4], cfg_q[3],
                                           cfg_q[5], 1'b0, win[i].seq};
    end

    assign want   = pend_q | cfg_q[0];
    assign may_go = fifo_empty && (!bop_active || prio_mode == 2'b11);

    always_comb begin
        if (ser_busy || (want && may_go)) src = SRC_RPT;
        else if (bop_active)              src = SRC_BOP;
        else if (!fifo_empty)             src = SRC_FIFO;
        else                              src = SRC_RPT;
    end

    assign ser_en = bit_en && (src == SRC_RPT);

    prm_hdlc_tx #(.NBYTES(NBYTES)) tx_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ser_en),
        .req   (want && may_go),
        .body  (body),
        .nbit  (ser_bit),
        .busy  (ser_busy),
        .start (ser_start)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            pend_q <= 1'b0;
            dl_bit <= 1'b0;
            dl_src <= SRC_RPT;
        end else begin
            if (cfg_wr)         cfg_q    <= cfg_wdata & WMASK;
            else if (ser_start) cfg_q[0] <= 1'b0;
            if (ser_start)                              pend_q <= 1'b0;
            else if (one_sec && cfg_q[7] && !ser_busy)  pend_q <= 1'b1;
            if (bit_en) begin
                dl_src <= src;
                unique case (src)
                    SRC_FIFO: dl_bit <= fifo_bit;
                    SRC_BOP:  dl_bit <= bop_bit;
                    default:  dl_bit <= ser_bit;
                endcase
            end
        end
    end

    AST_CFG_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cfg_q == ($past(cfg_wdata) & WMASK))); // R1
    AST_SEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_start && !cfg_wr) |=> !cfg_q[0]); // R3
    AST_FIFO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        ser_start |-> fifo_empty); // R10
    AST_BOP_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_start && bop_active) |-> (prio_mode == 2'b11)); // R11
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(dl_bit) && $stable(dl_src))); // R13

endmodule

// File: tb/prm_inserter_tb.sv
`timescale 1ns/1ps
module prm_inserter_tb_top;
    logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, one_sec = 1'b0;
    logic crc_evt = 1'b0, fps_evt = 1'b0, sef_evt = 1'b0, fred_evt = 1'b0;
    logic cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0, cfg_q;
    logic [1:0] prio_mode = 2'b00, dl_src;
    logic fifo_empty = 1'b1, fifo_bit = 1'b0, bop_active = 1'b0, bop_bit = 1'b1, dl_bit;

    always #4 clk = ~clk;

    prm_inserter dut_i (.clk(clk), .rst_n(rst_n), .bit_en(bit_en), .one_sec(one_sec),
        .crc_evt(crc_evt), .fps_evt(fps_evt), .sef_evt(sef_evt), .fred_evt(fred_evt),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q), .prio_mode(prio_mode),
        .fifo_empty(fifo_empty), .fifo_bit(fifo_bit), .bop_active(bop_active),
        .bop_bit(bop_bit), .dl_bit(dl_bit), .dl_src(dl_src));

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    // receiver state
    logic [7:0] last8 = 8'h00;
    int ones = 0, nb = 0, frame_cnt = 0, bad_cnt = 0, flag_cnt = 0;
    int src1_cnt = 0, src2_cnt = 0, mism_cnt = 0;
    bit rb [0:255];
    logic [7:0] fr [0:31];
    int fr_len = 0;

    // model
    logic [10:0] mw [0:3];
    int mseq = 0;
    logic [7:0] mcfg = 8'h00;
    logic [7:0] ex [0:12];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_step(input logic [15:0] c, input bit b);
        logic fb;
        fb = c[0] ^ b;
        crc_step = c >> 1;
        if (fb) crc_step = crc_step ^ 16'h8408;
    endfunction

    function automatic logic [10:0] enc(input int c, input int f, input int s, input int r, input int sq);
        logic [5:0] g;
        if (c == 0) g = 6'd0;
        else if (c == 1) g = 6'b000001;
        else if (c <= 5) g = 6'b000010;
        else if (c <= 10) g = 6'b000100;
        else if (c <= 100) g = 6'b001000;
        else if (c <= 319) g = 6'b010000;
        else g = 6'b100000;
        enc = {g, s > 0, f > 0, r > 0, 2'(sq)};
    endfunction

    task automatic rx_bit(input bit b);
        last8 = {b, last8[7:1]};
        if (last8 == 8'h7E) begin
            int m;
            logic [15:0] c;
            flag_cnt++;
            m = nb - 7;
            if (m > 0) begin
                c = 16'hFFFF;
                if (m <= 256) for (int i = 0; i < m; i++) c = crc_step(c, rb[i]);
                if (m <= 256 && m % 8 == 0 && m >= 24 && c == 16'hF0B8) begin
                    fr_len = m / 8;
                    for (int i = 0; i < fr_len && i < 32; i++)
                        for (int j = 0; j < 8; j++) fr[i][j] = rb[i*8+j];
                    frame_cnt++;
                end else bad_cnt++;
            end
            nb = 0;
            ones = 0;
        end else if (ones == 5 && b == 1'b0) begin
            ones = 0;
        end else begin
            if (nb < 256) rb[nb] = b;
            nb++;
            ones = b ? ones + 1 : 0;
        end
    endtask

    // bit slot generator and sampler
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            bit_en = 1'b1;
            @(negedge clk);
            bit_en = 1'b0;
            if (dl_src == 2'd0) rx_bit(dl_bit);
            else if (dl_src == 2'd1) begin
                src1_cnt++;
                if (dl_bit !== fifo_bit) mism_cnt++;
            end else if (dl_src == 2'd2) begin
                src2_cnt++;
                if (dl_bit !== bop_bit) mism_cnt++;
            end else mism_cnt++;
            fifo_bit = ~fifo_bit;
            bop_bit  = $urandom_range(0, 1);
        end
    end

    task automatic wait_slots(input int n);
        repeat (n * 4) @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [7:0] v);
        cfg_wdata = v;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        mcfg = v & 8'hFD;
    endtask

    task automatic drive_second(input int c, input int f, input int s, input int r);
        int mx;
        mx = c;
        if (f > mx) mx = f;
        if (s > mx) mx = s;
        if (r > mx) mx = r;
        for (int i = 0; i < mx; i++) begin
            crc_evt = (i < c); fps_evt = (i < f); sef_evt = (i < s); fred_evt = (i < r);
            @(negedge clk);
        end
        crc_evt = 0; fps_evt = 0; sef_evt = 0; fred_evt = 0;
        one_sec = 1'b1;
        @(negedge clk);
        one_sec = 1'b0;
        for (int k = 3; k > 0; k--) mw[k] = mw[k-1];
        mw[0] = enc(c, f, s, r, mseq);
        mseq = (mseq + 1) % 4;
    endtask

    task automatic build_exp();
        ex[0] = {6'b001110, mcfg[6], 1'b0};
        ex[1] = 8'h01;
        ex[2] = 8'h03;
        for (int w = 0; w < 4; w++) begin
            ex[3+2*w] = mw[w][10:3];
            ex[4+2*w] = {mw[w][2], mcfg[2], mcfg[4], mcfg[3], mcfg[5], 1'b0, mw[w][1:0]};
        end
    endtask

    task automatic wait_frame(input int prev);
        int t;
        t = 0;
        while (frame_cnt == prev && t < 6000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic check_frame(input int prev);
        chk(frame_cnt == prev + 1, "R2 one report", frame_cnt - prev, 1);
        chk(fr_len == 13 && bad_cnt == 0, "R4 frame length/fcs", fr_len, 13);
        for (int i = 0; i < 3; i++) chk(fr[i] == ex[i], "R5 header", fr[i], ex[i]);
        for (int w = 0; w < 4; w++) begin
            chk(fr[3+2*w] == ex[3+2*w], "R6 window high octet", fr[3+2*w], ex[3+2*w]);
            chk(fr[4+2*w] == ex[4+2*w], "R8 window low octet", fr[4+2*w], ex[4+2*w]);
        end
        chk({fr[3][1:0], fr[4][7]} == {ex[3][1:0], ex[4][7]}, "R7 event flags",
            {fr[3][1:0], fr[4][7]}, {ex[3][1:0], ex[4][7]});
        chk(fr[4][6:2] == ex[4][6:2], "R9 fixed bits", fr[4][6:2], ex[4][6:2]);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int prev, edges [12];
        edges = '{0, 1, 2, 5, 6, 10, 11, 100, 101, 319, 320, 400};
        void'($urandom(32'd2024));
        for (int k = 0; k < 4; k++) mw[k] = '0;
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_q == 8'h00, "R1 reset value", cfg_q, 0);
        wait_slots(40);
        bad_cnt = 0;
        flag_cnt = 0;
        wait_slots(40);
        chk(flag_cnt >= 4 && frame_cnt == 0, "R13 idle flags", flag_cnt, 4);
        chk(dl_src == 2'd0, "R10 idle source", dl_src, 0);

        // register write; FIFO held busy so the send bit cannot start a frame
        fifo_empty = 1'b0;
        wr_cfg(8'hFF);
        chk(cfg_q == 8'hFD, "R1 reserved bit reads 0", cfg_q, 8'hFD);
        wr_cfg(8'h02);
        chk(cfg_q == 8'h00, "R1 write clear", cfg_q, 0);
        fifo_empty = 1'b1;
        wait_slots(20);

        // random seconds with auto on
        for (int s = 0; s < 6; s++) begin
            logic [7:0] v;
            v = 8'h80 | (8'($urandom) & 8'h7C);
            wr_cfg(v);
            prev = frame_cnt;
            drive_second(edges[$urandom_range(0, 11)], $urandom_range(0, 2),
                         $urandom_range(0, 2), $urandom_range(0, 2));
            build_exp();
            wait_frame(prev);
            check_frame(prev);
        end
        // directed bin edges
        for (int e = 0; e < 12; e++) begin
            prev = frame_cnt;
            drive_second(edges[e], e % 2, (e / 2) % 2, (e / 3) % 2);
            build_exp();
            wait_frame(prev);
            check_frame(prev);
        end

        // auto disabled
        wr_cfg(8'h14);
        prev = frame_cnt;
        drive_second(3, 1, 0, 0);
        wait_slots(300);
        chk(frame_cnt == prev, "R2 auto off sends nothing", frame_cnt - prev, 0);

        // one-shot send
        wr_cfg(8'h15);
        build_exp();
        wait_frame(prev);
        check_frame(prev);
        chk(cfg_q[0] == 1'b0, "R3 send bit self-clears", cfg_q[0], 0);
        wait_slots(300);
        chk(frame_cnt == prev + 1, "R3 single report", frame_cnt - prev, 1);

        // FIFO busy, two strobes while pending
        wr_cfg(8'hA8);
        fifo_empty = 1'b0;
        mism_cnt = 0; src1_cnt = 0;
        prev = frame_cnt;
        drive_second(7, 0, 1, 0);
        drive_second(150, 2, 0, 1);
        wait_slots(150);
        chk(frame_cnt == prev, "R10 report waits for FIFO", frame_cnt - prev, 0);
        chk(src1_cnt > 100 && mism_cnt == 0, "R10 FIFO bits pass", mism_cnt, 0);
        chk(dl_src == 2'd1, "R10 FIFO source code", dl_src, 1);
        fifo_empty = 1'b1;
        build_exp();
        wait_frame(prev);
        check_frame(prev);
        wait_slots(300);
        chk(frame_cnt == prev + 1, "R12 replaced, not queued twice", frame_cnt - prev, 1);

        // code words without priority, then with priority
        bop_active = 1'b1;
        prio_mode = 2'b00;
        src2_cnt = 0; mism_cnt = 0;
        prev = frame_cnt;
        drive_second(1, 1, 1, 1);
        wait_slots(150);
        chk(frame_cnt == prev, "R11 waits for code words", frame_cnt - prev, 0);
        chk(src2_cnt > 100 && mism_cnt == 0, "R11 code word bits pass", mism_cnt, 0);
        prio_mode = 2'b11;
        build_exp();
        wait_frame(prev);
        check_frame(prev);
        chk(bop_active == 1'b1, "R11 pre-empted running code words", bop_active, 1);
        bop_active = 1'b0;
        prio_mode = 2'b00;
        wait_slots(20);

        // strobe during transmission; FIFO turns busy mid-frame
        prev = frame_cnt;
        drive_second(12, 0, 0, 2);
        build_exp();
        wait_slots(40);
        fifo_empty = 1'b0;
        drive_second(4, 3, 3, 0);
        wait_frame(prev);
        check_frame(prev);
        fifo_empty = 1'b1;
        wait_slots(300);
        chk(frame_cnt == prev + 1, "R12 no report from mid-frame strobe", frame_cnt - prev, 1);
        chk(bad_cnt == 0, "R13 frame ran to closing flag", bad_cnt, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule